// File: doc/BRIEF.md
# Monochrome OLED Power-Up Command Sequencer

This block produces the configuration byte stream that a page-organised monochrome OLED controller needs after power-up. A one-cycle start pulse launches the sequence. The block then sends a fixed, ordered list of opcodes and their arguments over a valid/ready byte interface, one byte per accepted transfer. A downstream serial engine (SPI or I2C) consumes the stream. The block raises a single-cycle done pulse when the list is complete.

Static configuration inputs set the argument bytes. Several of these values are packed into shared bytes, and a few are offset or inverted before they are sent. Two groups of steps appear only when they are configured: the area-colour/low-power step and the lookup-table load. The configuration inputs must stay stable from the start pulse until done. A system normally ties contrast to 127 unless it needs a different level.

The command/data line output is low for the whole sequence, so every byte is marked as a command. The line returns high while the block is idle.

Top module: `oled_init_seq`

## Requirements
- R1: After reset, valid_o, done_o and busy_o are low and dc_o is high.
- R2: The accepted bytes follow this order: 0x81 then contrast; segment remap; COM scan; 0xA8 then height-1; 0xD3 then COM offset; 0xD5 then clock byte; optional area step; 0xD9 then precharge byte; 0xDA then COM pins byte; 0xDB then VCOMH; 0x8D then pump byte; optional lookup table; 0x20 then address mode.
- R3: The segment remap byte is 0xA0 with seg_remap_i in bit 0. The COM scan byte is 0xC0 with com_inv_i in bit 3.
- R4: The multiplex argument is height_i minus 1, and the display offset argument is com_offset_i unchanged.
- R5: The clock byte carries (clk_div_i - 1) in bits 3:0 and clk_frq_i in bits 7:4.
- R6: The precharge byte carries pre1_i in bits 3:0 and pre2_i in bits 7:4.
- R7: The COM pins byte always has bit 1 set. Its bit 4 is the inverse of com_seq_i and its bit 5 is com_lr_i. All other bits are 0.
- R8: The 0xD8 step is sent only when area_color_i or low_power_i is high. Its argument is the OR of 0x1E (area colour) and 0x05 (low power).
- R9: The charge pump byte is 0x10, with bit 2 added when pump_need_i is high.
- R10: When lut_en_i is high, 0x91 is followed by the LUT_N table bytes, entry 0 first, where entry i is lut_i[8i+7:8i]. When lut_en_i is low, no table bytes are sent.
- R11: The address mode argument is 0x02 when page_mode_i is high and 0x00 when it is low. It is the last byte.
- R12: While valid_o is high and ready_i is low, valid_o and data_o hold their values in the next cycle.
- R13: done_o is high for exactly one cycle, the cycle after the last byte is accepted. busy_o falls in that same cycle.
- R14: dc_o is low whenever valid_o is high. A start pulse while busy_o is high has no effect, so exactly one sequence is sent and no bytes follow done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, ignored while busy |
| contrast_i | input | 8 | Contrast level |
| height_i | input | 8 | Panel height in rows |
| com_offset_i | input | 8 | Display offset in COM lines |
| clk_div_i | input | 5 | Display clock divider, 1 to 16 |
| clk_frq_i | input | 4 | Oscillator frequency code |
| pre1_i | input | 4 | Precharge phase 1 length |
| pre2_i | input | 4 | Precharge phase 2 length |
| vcomh_i | input | 8 | VCOMH deselect level |
| seg_remap_i | input | 1 | Segment remap enable |
| com_inv_i | input | 1 | Reverse COM scan direction |
| com_seq_i | input | 1 | Sequential COM pin layout |
| com_lr_i | input | 1 | COM left/right swap |
| area_color_i | input | 1 | Area colour enable |
| low_power_i | input | 1 | Low-power display enable |
| pump_need_i | input | 1 | Internal charge pump required |
| lut_en_i | input | 1 | Send the lookup table |
| lut_i | input | 8*LUT_N | Lookup table entries, entry 0 in the low byte |
| page_mode_i | input | 1 | Page addressing (else horizontal) |
| ready_i | input | 1 | Downstream accepts the byte |
| valid_o | output | 1 | Byte on data_o is valid |
| data_o | output | 8 | Command byte |
| dc_o | output | 1 | Command/data line, low for commands |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions check every cycle that a stalled byte holds its value and valid stays high, that dc_o is low under valid, that done is a single pulse following an accepted address-mode byte with busy dropped, and that the reset state is correct. The bench's behavioural model is the only check on byte content and order. Only the bench shows that optional steps are inserted or skipped for each flag combination, that the fields are packed and inverted correctly, and that a start pulse in mid-sequence starts nothing more. Its scenarios use different back-pressure patterns against the same model.

// File: rtl/oled_init_pkg.sv
package oled_init_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [4:0] {
    ST_CTR_OP, ST_CTR_ARG, ST_SEG, ST_COM,
    ST_MUX_OP, ST_MUX_ARG, ST_OFS_OP, ST_OFS_ARG,
    ST_CLK_OP, ST_CLK_ARG, ST_AREA_OP, ST_AREA_ARG,
    ST_PRE_OP, ST_PRE_ARG, ST_PINS_OP, ST_PINS_ARG,
    ST_VCH_OP, ST_VCH_ARG, ST_PUMP_OP, ST_PUMP_ARG,
    ST_LUT_OP, ST_LUT_ENT, ST_ADDR_OP, ST_ADDR_ARG
  } step_e;

  localparam logic [7:0] OP_CONTRAST = 8'h81;
  localparam logic [7:0] OP_SEG      = 8'hA0;
  localparam logic [7:0] OP_COM      = 8'hC0;
  localparam logic [7:0] OP_MUX      = 8'hA8;
  localparam logic [7:0] OP_OFFSET   = 8'hD3;
  localparam logic [7:0] OP_CLOCK    = 8'hD5;
  localparam logic [7:0] OP_AREA     = 8'hD8;
  localparam logic [7:0] OP_PRECHG   = 8'hD9;
  localparam logic [7:0] OP_PINS     = 8'hDA;
  localparam logic [7:0] OP_VCOMH    = 8'hDB;
  localparam logic [7:0] OP_PUMP     = 8'h8D;
  localparam logic [7:0] OP_LUT      = 8'h91;
  localparam logic [7:0] OP_ADDR     = 8'h20;
endpackage

// File: rtl/oled_step_ctrl.sv
module oled_step_ctrl
  import oled_init_pkg::*;
#(
  parameter int LUT_N = 4,
  localparam int IW = (LUT_N > 1) ? $clog2(LUT_N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ready_i,
  input  logic          skip_area_i,
  input  logic          skip_lut_i,
  output step_e         step_o,
  output logic [IW-1:0] lut_idx_o,
  output logic          run_o,
  output logic          valid_o,
  output logic          done_o
);
  step_e         step_q;
  logic [IW-1:0] idx_q;
  logic          run_q, done_q;
  logic          in_area, in_lut, skip, adv, last;

  assign in_area = (step_q == ST_AREA_OP) || (step_q == ST_AREA_ARG);
  assign in_lut  = (step_q == ST_LUT_OP) || (step_q == ST_LUT_ENT);
  assign skip    = (in_area && skip_area_i) || (in_lut && skip_lut_i);
  assign adv     = run_q && (skip || ready_i);
  assign last    = (step_q == ST_ADDR_ARG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_CTR_OP;
      idx_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= adv && last;
      if (!run_q) begin
        if (start_i) begin
          run_q  <= 1'b1;
          step_q <= ST_CTR_OP;
          idx_q  <= '0;
        end
      end else if (adv) begin
        if (last) begin
          run_q <= 1'b0;
        end else if (step_q == ST_LUT_ENT && !skip && idx_q != IW'(LUT_N - 1)) begin
          idx_q <= idx_q + 1'b1;
        end else begin
          step_q <= step_e'(5'(step_q) + 5'd1);
          idx_q  <= '0;
        end
      end
    end
  end

  assign step_o    = step_q;
  assign lut_idx_o = idx_q;
  assign run_o     = run_q;
  assign valid_o   = run_q && !skip;
  assign done_o    = done_q;
endmodule

// File: rtl/oled_byte_fmt.sv
module oled_byte_fmt
  import oled_init_pkg::*;
#(
  parameter int LUT_N = 4,
  localparam int IW = (LUT_N > 1) ? $clog2(LUT_N) : 1
) (
  input  step_e                 step_i,
  input  logic [IW-1:0]         lut_idx_i,
  input  logic [7:0]            contrast_i,
  input  logic [7:0]            height_i,
  input  logic [7:0]            com_offset_i,
  input  logic [4:0]            clk_div_i,
  input  logic [3:0]            clk_frq_i,
  input  logic [3:0]            pre1_i,
  input  logic [3:0]            pre2_i,
  input  logic [7:0]            vcomh_i,
  input  logic                  seg_remap_i,
  input  logic                  com_inv_i,
  input  logic                  com_seq_i,
  input  logic                  com_lr_i,
  input  logic                  area_color_i,
  input  logic                  low_power_i,
  input  logic                  pump_need_i,
  input  logic [8*LUT_N-1:0]    lut_i,
  input  logic                  page_mode_i,
  output logic [BYTE_W-1:0]     byte_o
);
  logic [4:0] div_m1;
  logic [7:0] area_arg;
  logic [7:0] lut_byte;

  assign div_m1   = clk_div_i - 5'd1;
  assign area_arg = (area_color_i ? 8'h1E : 8'h00) | (low_power_i ? 8'h05 : 8'h00);

  always_comb begin
    lut_byte = 8'h00;
    for (int i = 0; i < LUT_N; i++)
      if (lut_idx_i == IW'(i)) lut_byte = lut_i[8*i +: 8];
  end

  always_comb begin
    unique case (step_i)
      ST_CTR_OP:   byte_o = OP_CONTRAST;
      ST_CTR_ARG:  byte_o = contrast_i;
      ST_SEG:      byte_o = OP_SEG | {7'd0, seg_remap_i};
      ST_COM:      byte_o = OP_COM | {4'd0, com_inv_i, 3'd0};
      ST_MUX_OP:   byte_o = OP_MUX;
      ST_MUX_ARG:  byte_o = height_i - 8'd1;
      ST_OFS_OP:   byte_o = OP_OFFSET;
      ST_OFS_ARG:  byte_o = com_offset_i;
      ST_CLK_OP:   byte_o = OP_CLOCK;
      ST_CLK_ARG:  byte_o = {clk_frq_i, div_m1[3:0]};
      ST_AREA_OP:  byte_o = OP_AREA;
      ST_AREA_ARG: byte_o = area_arg;
      ST_PRE_OP:   byte_o = OP_PRECHG;
      ST_PRE_ARG:  byte_o = {pre2_i, pre1_i};
      ST_PINS_OP:  byte_o = OP_PINS;
      ST_PINS_ARG: byte_o = {2'b00, com_lr_i, ~com_seq_i, 4'b0010};
      ST_VCH_OP:   byte_o = OP_VCOMH;
      ST_VCH_ARG:  byte_o = vcomh_i;
      ST_PUMP_OP:  byte_o = OP_PUMP;
      ST_PUMP_ARG: byte_o = {3'b000, 1'b1, 1'b0, pump_need_i, 2'b00};
      ST_LUT_OP:   byte_o = OP_LUT;
      ST_LUT_ENT:  byte_o = lut_byte;
      ST_ADDR_OP:  byte_o = OP_ADDR;
      ST_ADDR_ARG: byte_o = page_mode_i ? 8'h02 : 8'h00;
      default:     byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq
  import oled_init_pkg::*;
#(
  parameter int LUT_N = 4,
  localparam int IW = (LUT_N > 1) ? $clog2(LUT_N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         contrast_i,
  input  logic [7:0]         height_i,
  input  logic [7:0]         com_offset_i,
  input  logic [4:0]         clk_div_i,
  input  logic [3:0]         clk_frq_i,
  input  logic [3:0]         pre1_i,
  input  logic [3:0]         pre2_i,
  input  logic [7:0]         vcomh_i,
  input  logic               seg_remap_i,
  input  logic               com_inv_i,
  input  logic               com_seq_i,
  input  logic               com_lr_i,
  input  logic               area_color_i,
  input  logic               low_power_i,
  input  logic               pump_need_i,
  input  logic               lut_en_i,
  input  logic [8*LUT_N-1:0] lut_i,
  input  logic               page_mode_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [7:0]         data_o,
  output logic               dc_o,
  output logic               busy_o,
  output logic               done_o
);
  step_e         step;
  logic [IW-1:0] lut_idx;
  logic          run;

  oled_step_ctrl #(.LUT_N(LUT_N)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ready_i     (ready_i),
    .skip_area_i (!(area_color_i || low_power_i)),
    .skip_lut_i  (!lut_en_i),
    .step_o      (step),
    .lut_idx_o   (lut_idx),
    .run_o       (run),
    .valid_o     (valid_o),
    .done_o      (done_o)
  );

  oled_byte_fmt #(.LUT_N(LUT_N)) u_fmt (
    .step_i       (step),
    .lut_idx_i    (lut_idx),
    .contrast_i   (contrast_i),
    .height_i     (height_i),
    .com_offset_i (com_offset_i),
    .clk_div_i    (clk_div_i),
    .clk_frq_i    (clk_frq_i),
    .pre1_i       (pre1_i),
    .pre2_i       (pre2_i),
    .vcomh_i      (vcomh_i),
    .seg_remap_i  (seg_remap_i),
    .com_inv_i    (com_inv_i),
    .com_seq_i    (com_seq_i),
    .com_lr_i     (com_lr_i),
    .area_color_i (area_color_i),
    .low_power_i  (low_power_i),
    .pump_need_i  (pump_need_i),
    .lut_i        (lut_i),
    .page_mode_i  (page_mode_i),
    .byte_o       (data_o)
  );

  assign busy_o = run;
  assign dc_o   = ~run;
endmodule

// File: rtl/oled_init_seq_chk.sv
module oled_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_i,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       dc_o,
  input logic       busy_o,
  input logic       done_o
);
  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_IDLE: assert (!valid_o && !done_o && !busy_o); // R1

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R12

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !valid_o); // R13

  AST_DONE_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_o && ready_i && (data_o == 8'h00 || data_o == 8'h02))); // R11

  AST_DC_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !dc_o); // R14
endmodule

bind oled_init_seq oled_init_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (ready_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .dc_o    (dc_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/oled_init_seq_tb.sv
module oled_init_seq_tb;
  localparam int LUT_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, ready = 1;
  logic [7:0] contrast = 8'd127, height = 8'd64, com_ofs = 8'd0, vcomh = 8'h20;
  logic [4:0] clk_div = 5'd1;
  logic [3:0] clk_frq = 4'd8, pre1 = 4'd2, pre2 = 4'd2;
  logic seg_remap = 1, com_inv = 0, com_seq = 0, com_lr = 0;
  logic area = 0, lowp = 0, pump = 1, lut_en = 0, page = 0;
  logic [8*LUT_N-1:0] lut = 32'h3F3E_201F;
  logic valid, dc, busy, done;
  logic [7:0] data;

  oled_init_seq #(.LUT_N(LUT_N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .contrast_i(contrast),
    .height_i(height), .com_offset_i(com_ofs), .clk_div_i(clk_div),
    .clk_frq_i(clk_frq), .pre1_i(pre1), .pre2_i(pre2), .vcomh_i(vcomh),
    .seg_remap_i(seg_remap), .com_inv_i(com_inv), .com_seq_i(com_seq),
    .com_lr_i(com_lr), .area_color_i(area), .low_power_i(lowp),
    .pump_need_i(pump), .lut_en_i(lut_en), .lut_i(lut), .page_mode_i(page),
    .ready_i(ready), .valid_o(valid), .data_o(data), .dc_o(dc),
    .busy_o(busy), .done_o(done)
  );

  int errors = 0, checks = 0, cyc = 0, rdy_mode = 0;
  logic [7:0] expq[$];
  string tagq[$];
  logic exp_done = 0;
  logic mon_en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string t);
    expq.push_back(b);
    tagq.push_back(t);
  endtask

  // Behavioural model of the expected stream
  task automatic build;
    expq.delete(); tagq.delete();
    push(8'h81, "R2"); push(contrast, "R2");
    push(8'hA0 + 8'(seg_remap), "R3");
    push(8'hC0 + (com_inv ? 8'd8 : 8'd0), "R3");
    push(8'hA8, "R2"); push(height - 8'd1, "R4");
    push(8'hD3, "R2"); push(com_ofs, "R4");
    push(8'hD5, "R2"); push(8'(clk_frq) * 16 + 8'((clk_div - 5'd1) % 16), "R5");
    if (area || lowp) begin
      push(8'hD8, "R8"); push((area ? 8'h1E : 8'h00) | (lowp ? 8'h05 : 8'h00), "R8");
    end
    push(8'hD9, "R2"); push(8'(pre2) * 16 + 8'(pre1), "R6");
    push(8'hDA, "R2"); push(8'h02 + (com_seq ? 8'h00 : 8'h10) + (com_lr ? 8'h20 : 8'h00), "R7");
    push(8'hDB, "R2"); push(vcomh, "R2");
    push(8'h8D, "R2"); push(pump ? 8'h14 : 8'h10, "R9");
    if (lut_en) begin
      push(8'h91, "R10");
      for (int i = 0; i < LUT_N; i++) push(lut[8*i +: 8], "R10");
    end
    push(8'h20, "R2"); push(page ? 8'h02 : 8'h00, "R11");
  endtask

  // Back-pressure patterns
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: ready = 1'b1;
      1: ready = cyc[0];
      default: ready = (cyc % 3) != 0;
    endcase
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_en) begin
      if (done !== exp_done) chk(0, "R13", done, exp_done);
      else checks++;
      exp_done = 0;
      if (valid) begin
        if (dc !== 1'b0) chk(0, "R14", dc, 0);
        if (expq.size() == 0) chk(0, "R14", data, 0);
        else if (ready) begin
          logic [7:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(data === e, t, data, e);
          if (expq.size() == 0) exp_done = 1;
        end
      end
    end
  end

  task automatic run_seq(input int mode, input bit extra_start);
    int guard = 0;
    build();
    rdy_mode = mode;
    @(posedge clk); #2 start = 1;
    @(posedge clk); #2 start = 0;
    repeat (5) @(posedge clk);
    if (extra_start) begin
      #2 start = 1;
      @(posedge clk); #2 start = 0;
    end
    while (!done && guard < 500) begin @(negedge clk); guard++; end
    chk(guard < 500, "R13", guard, 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R13", {busy, done}, 0);
    chk(expq.size() == 0, "R2", expq.size(), 0);
    repeat (10) begin
      @(negedge clk);
      chk(valid === 1'b0 && dc === 1'b1, "R14", valid, 0);
    end
  endtask

  initial begin
    #1;
    chk(valid === 0 && done === 0 && busy === 0 && dc === 1, "R1", {valid, done, busy, dc}, 1);
    repeat (3) @(posedge clk);
    chk(valid === 0 && done === 0 && busy === 0 && dc === 1, "R1", {valid, done, busy, dc}, 1);
    #2 rst_n = 1;
    mon_en = 1;
    // Horizontal, no optional steps
    run_seq(0, 0);
    // Page mode, both optional groups, back-pressure, start while busy
    area = 1; lowp = 1; lut_en = 1; page = 1; com_seq = 1; com_lr = 1;
    com_inv = 1; seg_remap = 0; pump = 0; clk_div = 5'd16; clk_frq = 4'hF;
    pre1 = 4'hA; pre2 = 4'h5; contrast = 8'hC3; height = 8'd16; com_ofs = 8'd7;
    vcomh = 8'h34;
    run_seq(1, 1);
    // Low power only, irregular ready
    area = 0; lowp = 1; lut_en = 0; page = 0; clk_div = 5'd2; clk_frq = 4'hC;
    run_seq(2, 1);
    // Area colour only, table loaded, horizontal
    area = 1; lowp = 0; lut_en = 1; lut = 32'h2A29_3331; com_seq = 0;
    run_seq(2, 0);
    mon_en = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule